// File: doc/BRIEF.md
# Scrambled Control-Character Link Codec

This block sits between a framing layer and an 8b/10b encoder on a serial link that carries real-time bytes alongside a slow non-real-time side channel. While the link is still coming up, the transmit side emits nothing but the comma character so that the far end can align. Once the link is declared up, commas stop completely. From then on, each symbol slot carries either a scrambled real-time payload byte as a data character, or a control character. The control character is chosen from a fixed set of eight by a 3-bit word that has been XORed with a pseudo-random sequence. Real-time data always takes the slot when present. Every run of real-time bytes is therefore bounded by control characters, and the idle gaps spread their energy instead of repeating one pattern.

The 3-bit word encodes a side-channel frame delimiter, two side-channel data bits, or plain idle. Two independent LFSRs scramble the control words and the payload bytes. Both restart from fixed seeds whenever the transmitter leaves the comma phase, and whenever the receiver sees a comma. The receive half of the block runs the same pair of LFSRs. It recovers the payload bytes and the side-channel symbols, and flags any control character it does not expect.

Top module: `ctlchar_link_codec`

## Requirements
- R1: While `link_up` is low (and during reset) the transmitter outputs the comma `tx_k`=1, `tx_data`=0xBC on every symbol, one cycle after the input is sampled.
- R2: With `link_up` high and `rt_valid` high, the next symbol is a data character (`tx_k`=0) equal to `rt_data` XOR bits [7:0] of the data LFSR. After link-up, no comma (0x3C, 0xBC, 0xFC with k=1) is ever sent.
- R3: Each LFSR is 16 bits wide and steps as s' = {s[14:0], ^(s & 16'hB400)}. The control LFSR has seed 0x1D0F and the data LFSR has seed 0xACE1. Both sit at their seed while `link_up` is low. Both step once per transmitted symbol while it is high. The first symbol after link-up uses the seeds.
- R4: With `link_up` high and no real-time byte, the transmitter sends `tx_k`=1 and the character at index (w XOR control LFSR bits [2:0]) of the table {0x1C,0x5C,0x7C,0x9C,0xDC,0xF7,0xFB,0xFD}, where index 0 is the first entry. Here w is 3'b100 for a delimiter, {1'b0,X,Y} for side-channel bits XY, and 3'b111 for idle.
- R5: `nrt_accept` is combinationally `link_up & nrt_valid & ~rt_valid`. When real-time data is present, the offered side-channel symbol is not sent and is not accepted.
- R6: The receiver becomes synchronised on a received comma and reloads both seeds there. It then steps both LFSRs on every non-comma symbol. One cycle after each symbol it reports a data character as `rx_rt_valid` with the descrambled byte. It reports a delimiter as `rx_nrt_valid`+`rx_nrt_delim`, and data bits as `rx_nrt_valid` with `rx_nrt_bits`. Idle produces no output strobe.
- R7: A synchronised receiver that gets a control character outside the eight-entry set (other than 0xBC) raises `rx_err` for one cycle and reports no data or side-channel symbol for it.
- R8: With transmitter output looped to receiver input, a byte or side-channel symbol appears at the receive outputs two cycles after it is presented. This also holds after the link drops and comes back up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up | input | 1 | High once link initialisation is done |
| rt_valid | input | 1 | Real-time byte present this symbol |
| rt_data | input | DW | Real-time payload byte |
| nrt_valid | input | 1 | Side-channel symbol offered |
| nrt_delim | input | 1 | Offered symbol is a frame delimiter |
| nrt_bits | input | 2 | Two side-channel data bits |
| nrt_accept | output | 1 | Offered side-channel symbol is taken this cycle |
| tx_data | output | 8 | Character to the 8b/10b encoder |
| tx_k | output | 1 | Character is a control character |
| rx_data | input | 8 | Character from the 8b/10b decoder |
| rx_k | input | 1 | Received character is a control character |
| rx_rt_valid | output | 1 | Descrambled real-time byte valid |
| rx_rt_data | output | DW | Descrambled real-time byte |
| rx_nrt_valid | output | 1 | Side-channel symbol received |
| rx_nrt_delim | output | 1 | Received symbol is a delimiter |
| rx_nrt_bits | output | 2 | Received side-channel data bits |
| rx_err | output | 1 | Unexpected control character received |

## Verification
`nrt_accept` is combinational, so it is checked a few nanoseconds after inputs change, within the same cycle. A transmitted symbol is due one clock edge after its inputs. With the bench's loopback, the matching receive result is due two edges after. Each expected item is pushed to a queue stamped with the cycle in which it falls due. The monitor compares only items whose stamp equals the current cycle, and it samples on the falling edge. Error injection replaces the received character exactly in the slot where the receiver registers it, so the result is due at the same two-edge mark.

// File: rtl/ctlchar_link_pkg.sv
package ctlchar_link_pkg;

   localparam logic [7:0] COMMA_CHAR = 8'hBC;
   localparam logic [2:0] WORD_DELIM = 3'b100;
   localparam logic [2:0] WORD_IDLE  = 3'b111;

   // Eight non-comma control characters used after link-up
   function automatic logic [7:0] ctrl_char(input logic [2:0] idx);
      logic [7:0] c;
      case (idx)
         3'd0:    c = 8'h1C;
         3'd1:    c = 8'h5C;
         3'd2:    c = 8'h7C;
         3'd3:    c = 8'h9C;
         3'd4:    c = 8'hDC;
         3'd5:    c = 8'hF7;
         3'd6:    c = 8'hFB;
         default: c = 8'hFD;
      endcase
      return c;
   endfunction

   // {hit, index} for a received control character
   function automatic logic [3:0] ctrl_index(input logic [7:0] c);
      logic [3:0] r;
      r = 4'b0000;
      for (int i = 0; i < 8; i++) begin
         if (ctrl_char(3'(i)) == c) r = {1'b1, 3'(i)};
      end
      return r;
   endfunction

   function automatic logic ctrl_hit(input logic [7:0] c);
      logic [3:0] r;
      r = ctrl_index(c);
      return r[3];
   endfunction

endpackage

// File: rtl/ctlchar_link_lfsr.sv
module ctlchar_link_lfsr #(
   parameter int unsigned   W    = 16,
   parameter int unsigned   OW   = 8,
   parameter logic [W-1:0]  TAPS = 16'hB400,
   parameter logic [W-1:0]  SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reload,
   input  logic          step,
   output logic [OW-1:0] bits
);

   logic [W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st <= SEED;
      else if (reload) st <= SEED;
      else if (step)   st <= {st[W-2:0], ^(st & TAPS)};
   end

   assign bits = st[OW-1:0];

endmodule

// File: rtl/ctlchar_link_enc.sv
module ctlchar_link_enc
   import ctlchar_link_pkg::*;
#(
   parameter int unsigned    DW        = 8,
   parameter int unsigned    LW        = 16,
   parameter logic [LW-1:0]  CTRL_TAPS = 16'hB400,
   parameter logic [LW-1:0]  CTRL_SEED = 16'h1D0F,
   parameter logic [LW-1:0]  DATA_TAPS = 16'hB400,
   parameter logic [LW-1:0]  DATA_SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_up,
   input  logic          rt_valid,
   input  logic [DW-1:0] rt_data,
   input  logic          nrt_valid,
   input  logic          nrt_delim,
   input  logic [1:0]    nrt_bits,
   output logic          nrt_accept,
   output logic [7:0]    tx_data,
   output logic          tx_k
);

   logic [2:0]    cmask;
   logic [DW-1:0] dmask;
   logic [2:0]    word;

   ctlchar_link_lfsr #(.W(LW), .OW(3), .TAPS(CTRL_TAPS), .SEED(CTRL_SEED)) u_cscr (
      .clk(clk), .rst_n(rst_n), .reload(!link_up), .step(link_up), .bits(cmask));

   ctlchar_link_lfsr #(.W(LW), .OW(DW), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) u_dscr (
      .clk(clk), .rst_n(rst_n), .reload(!link_up), .step(link_up), .bits(dmask));

   assign nrt_accept = link_up & nrt_valid & ~rt_valid;

   always_comb begin
      if (!nrt_accept)   word = WORD_IDLE;
      else if (nrt_delim) word = WORD_DELIM;
      else               word = {1'b0, nrt_bits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_data <= COMMA_CHAR;
         tx_k    <= 1'b1;
      end else if (!link_up) begin
         tx_data <= COMMA_CHAR;
         tx_k    <= 1'b1;
      end else if (rt_valid) begin
         tx_data <= rt_data ^ dmask;
         tx_k    <= 1'b0;
      end else begin
         tx_data <= ctrl_char(word ^ cmask);
         tx_k    <= 1'b1;
      end
   end

endmodule

// File: rtl/ctlchar_link_dec.sv
module ctlchar_link_dec
   import ctlchar_link_pkg::*;
#(
   parameter int unsigned    DW        = 8,
   parameter int unsigned    LW        = 16,
   parameter logic [LW-1:0]  CTRL_TAPS = 16'hB400,
   parameter logic [LW-1:0]  CTRL_SEED = 16'h1D0F,
   parameter logic [LW-1:0]  DATA_TAPS = 16'hB400,
   parameter logic [LW-1:0]  DATA_SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    rx_data,
   input  logic          rx_k,
   output logic          rx_rt_valid,
   output logic [DW-1:0] rx_rt_data,
   output logic          rx_nrt_valid,
   output logic          rx_nrt_delim,
   output logic [1:0]    rx_nrt_bits,
   output logic          rx_err
);

   logic          synced;
   logic          is_comma;
   logic          adv;
   logic [2:0]    cmask;
   logic [DW-1:0] dmask;
   logic [3:0]    look;
   logic [2:0]    word;

   assign is_comma = rx_k && (rx_data == COMMA_CHAR);
   assign adv      = synced && !is_comma;
   assign look     = ctrl_index(rx_data);
   assign word     = look[2:0] ^ cmask;

   ctlchar_link_lfsr #(.W(LW), .OW(3), .TAPS(CTRL_TAPS), .SEED(CTRL_SEED)) u_cscr (
      .clk(clk), .rst_n(rst_n), .reload(is_comma), .step(adv), .bits(cmask));

   ctlchar_link_lfsr #(.W(LW), .OW(DW), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) u_dscr (
      .clk(clk), .rst_n(rst_n), .reload(is_comma), .step(adv), .bits(dmask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced       <= 1'b0;
         rx_rt_valid  <= 1'b0;
         rx_rt_data   <= '0;
         rx_nrt_valid <= 1'b0;
         rx_nrt_delim <= 1'b0;
         rx_nrt_bits  <= 2'b00;
         rx_err       <= 1'b0;
      end else begin
         rx_rt_valid  <= 1'b0;
         rx_nrt_valid <= 1'b0;
         rx_nrt_delim <= 1'b0;
         rx_err       <= 1'b0;
         if (is_comma) begin
            synced <= 1'b1;
         end else if (synced) begin
            if (!rx_k) begin
               rx_rt_valid <= 1'b1;
               rx_rt_data  <= rx_data[DW-1:0] ^ dmask;
            end else if (!look[3]) begin
               rx_err <= 1'b1;
            end else if (word == WORD_DELIM) begin
               rx_nrt_valid <= 1'b1;
               rx_nrt_delim <= 1'b1;
            end else if (!word[2]) begin
               rx_nrt_valid <= 1'b1;
               rx_nrt_bits  <= word[1:0];
            end
         end
      end
   end

endmodule

// File: rtl/ctlchar_link_codec.sv
module ctlchar_link_codec #(
   parameter int unsigned    DW        = 8,
   parameter int unsigned    LW        = 16,
   parameter logic [LW-1:0]  CTRL_TAPS = 16'hB400,
   parameter logic [LW-1:0]  CTRL_SEED = 16'h1D0F,
   parameter logic [LW-1:0]  DATA_TAPS = 16'hB400,
   parameter logic [LW-1:0]  DATA_SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_up,
   input  logic          rt_valid,
   input  logic [DW-1:0] rt_data,
   input  logic          nrt_valid,
   input  logic          nrt_delim,
   input  logic [1:0]    nrt_bits,
   output logic          nrt_accept,
   output logic [7:0]    tx_data,
   output logic          tx_k,
   input  logic [7:0]    rx_data,
   input  logic          rx_k,
   output logic          rx_rt_valid,
   output logic [DW-1:0] rx_rt_data,
   output logic          rx_nrt_valid,
   output logic          rx_nrt_delim,
   output logic [1:0]    rx_nrt_bits,
   output logic          rx_err
);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("ctlchar_link_codec: DW must equal the 8-bit character width");
      end
      if (LW < DW || LW < 3) begin : g_bad_lw
         $error("ctlchar_link_codec: LW must cover the data and control masks");
      end
      if (CTRL_SEED == '0 || DATA_SEED == '0) begin : g_bad_seed
         $error("ctlchar_link_codec: LFSR seeds must be non-zero");
      end
   endgenerate

   ctlchar_link_enc #(
      .DW(DW), .LW(LW),
      .CTRL_TAPS(CTRL_TAPS), .CTRL_SEED(CTRL_SEED),
      .DATA_TAPS(DATA_TAPS), .DATA_SEED(DATA_SEED)
   ) u_enc (
      .clk(clk), .rst_n(rst_n), .link_up(link_up),
      .rt_valid(rt_valid), .rt_data(rt_data),
      .nrt_valid(nrt_valid), .nrt_delim(nrt_delim), .nrt_bits(nrt_bits),
      .nrt_accept(nrt_accept), .tx_data(tx_data), .tx_k(tx_k));

   ctlchar_link_dec #(
      .DW(DW), .LW(LW),
      .CTRL_TAPS(CTRL_TAPS), .CTRL_SEED(CTRL_SEED),
      .DATA_TAPS(DATA_TAPS), .DATA_SEED(DATA_SEED)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_k(rx_k),
      .rx_rt_valid(rx_rt_valid), .rx_rt_data(rx_rt_data),
      .rx_nrt_valid(rx_nrt_valid), .rx_nrt_delim(rx_nrt_delim),
      .rx_nrt_bits(rx_nrt_bits), .rx_err(rx_err));

endmodule

// File: rtl/ctlchar_link_codec_chk.sv
module ctlchar_link_codec_chk
   import ctlchar_link_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       link_up,
   input logic       rt_valid,
   input logic       nrt_accept,
   input logic [7:0] tx_data,
   input logic       tx_k,
   input logic       rx_rt_valid,
   input logic       rx_nrt_valid,
   input logic       rx_err
);

   AST_COMMA_WHILE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> (tx_k && tx_data == COMMA_CHAR));  // R1

   AST_NO_COMMA_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |=> !(tx_k && (tx_data == 8'h3C || tx_data == 8'hBC || tx_data == 8'hFC)));  // R2

   AST_RT_AS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && rt_valid) |=> !tx_k);  // R2

   AST_CTRL_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && !rt_valid) |=> (tx_k && ctrl_hit(tx_data)));  // R4

   AST_RT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      rt_valid |-> !nrt_accept);  // R5

   AST_RX_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rx_rt_valid, rx_nrt_valid, rx_err}) <= 1);  // R6

endmodule

bind ctlchar_link_codec ctlchar_link_codec_chk u_chk (
   .clk(clk), .rst_n(rst_n), .link_up(link_up), .rt_valid(rt_valid),
   .nrt_accept(nrt_accept), .tx_data(tx_data), .tx_k(tx_k),
   .rx_rt_valid(rx_rt_valid), .rx_nrt_valid(rx_nrt_valid), .rx_err(rx_err));

// File: tb/ctlchar_link_codec_test.sv
`timescale 1ns/1ps
module ctlchar_link_codec_test;

   typedef struct packed {
      int         due;
      logic       k;
      logic [7:0] d;
   } tx_item_t;

   typedef struct packed {
      int         due;
      logic       rtv;
      logic [7:0] rtd;
      logic       nv;
      logic       nd;
      logic [1:0] nb;
      logic       err;
   } rx_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_up = 1'b0, rt_valid = 1'b0, nrt_valid = 1'b0, nrt_delim = 1'b0;
   logic [7:0] rt_data = 8'h00;
   logic [1:0] nrt_bits = 2'b00;
   logic nrt_accept, tx_k, rx_k;
   logic [7:0] tx_data, rx_data, rx_rt_data;
   logic rx_rt_valid, rx_nrt_valid, rx_nrt_delim, rx_err;
   logic [1:0] rx_nrt_bits;
   logic inj_a = 1'b0, inj_b = 1'b0, inj_c = 1'b0;

   int cyc = 0;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   tx_item_t txq[$];
   string    txtag[$];
   rx_item_t rxq[$];
   string    rxtag[$];

   logic [15:0] mc = 16'h1D0F;
   logic [15:0] md = 16'hACE1;

   always #10 clk = ~clk;  // 50 MHz

   assign rx_data = inj_c ? 8'hFE : tx_data;
   assign rx_k    = inj_c ? 1'b1  : tx_k;

   ctlchar_link_codec uut (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .rt_valid(rt_valid), .rt_data(rt_data),
      .nrt_valid(nrt_valid), .nrt_delim(nrt_delim), .nrt_bits(nrt_bits),
      .nrt_accept(nrt_accept), .tx_data(tx_data), .tx_k(tx_k),
      .rx_data(rx_data), .rx_k(rx_k), .rx_rt_valid(rx_rt_valid), .rx_rt_data(rx_rt_data),
      .rx_nrt_valid(rx_nrt_valid), .rx_nrt_delim(rx_nrt_delim), .rx_nrt_bits(rx_nrt_bits),
      .rx_err(rx_err));

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      inj_b <= inj_a;
      inj_c <= inj_b;
   end

   function automatic logic [15:0] nxt(input logic [15:0] s);
      return {s[14:0], ^(s & 16'hB400)};
   endfunction

   function automatic logic [7:0] kch(input logic [2:0] i);
      logic [7:0] t [8] = '{8'h1C, 8'h5C, 8'h7C, 8'h9C, 8'hDC, 8'hF7, 8'hFB, 8'hFD};
      return t[i];
   endfunction

   task automatic drive(input bit up, input bit rtv, input logic [7:0] rtd,
                        input bit nv, input bit nd, input logic [1:0] nb,
                        input bit inj, input string tag);
      tx_item_t t;
      rx_item_t r;
      bit acc;
      logic [2:0] w;
      @(posedge clk);
      #2;
      link_up = up; rt_valid = rtv; rt_data = rtd;
      nrt_valid = nv; nrt_delim = nd; nrt_bits = nb; inj_a = inj;
      #1;
      acc = up && nv && !rtv;
      checks++;
      if (nrt_accept !== acc) begin
         failures++;
         $display("FAIL R5 nrt_accept actual=%0b expected=%0b (%s)", nrt_accept, acc, tag);
      end
      t = '0; r = '0;
      t.due = cyc + 1;
      r.due = cyc + 2;
      if (!up) begin
         t.k = 1'b1; t.d = 8'hBC;
         mc = 16'h1D0F; md = 16'hACE1;
      end else begin
         if (rtv) begin
            t.k = 1'b0; t.d = rtd ^ md[7:0];
            r.rtv = 1'b1; r.rtd = rtd;
         end else begin
            w = !acc ? 3'b111 : (nd ? 3'b100 : {1'b0, nb});
            t.k = 1'b1; t.d = kch(w ^ mc[2:0]);
            if (acc) begin
               r.nv = 1'b1; r.nd = nd; r.nb = nd ? 2'b00 : nb;
            end
         end
         mc = nxt(mc); md = nxt(md);
      end
      if (inj) begin
         r.rtv = 1'b0; r.nv = 1'b0; r.nd = 1'b0; r.err = 1'b1;
      end
      txq.push_back(t); txtag.push_back(tag);
      rxq.push_back(r); rxtag.push_back(tag);
   endtask

   // monitor: compares due items on the falling edge
   always @(negedge clk) begin
      while (txq.size() > 0 && txq[0].due == cyc) begin
         tx_item_t t;
         string g;
         t = txq.pop_front(); g = txtag.pop_front();
         checks++;
         if (tx_k !== t.k || tx_data !== t.d) begin
            failures++;
            $display("FAIL %s tx actual=k%0b/%02h expected=k%0b/%02h", g, tx_k, tx_data, t.k, t.d);
         end
      end
      while (rxq.size() > 0 && rxq[0].due == cyc) begin
         rx_item_t r;
         string g;
         bit bad;
         r = rxq.pop_front(); g = rxtag.pop_front();
         checks++;
         bad = (rx_rt_valid !== r.rtv) || (rx_nrt_valid !== r.nv) || (rx_err !== r.err) ||
               (r.rtv && rx_rt_data !== r.rtd) ||
               (r.nv && (rx_nrt_delim !== r.nd || (!r.nd && rx_nrt_bits !== r.nb)));
         if (bad) begin
            failures++;
            $display("FAIL %s rx actual=rt%0b/%02h nrt%0b/d%0b/%0b err%0b expected=rt%0b/%02h nrt%0b/d%0b/%0b err%0b",
                     g, rx_rt_valid, rx_rt_data, rx_nrt_valid, rx_nrt_delim, rx_nrt_bits, rx_err,
                     r.rtv, r.rtd, r.nv, r.nd, r.nb, r.err);
         end
      end
   end

   initial begin
      #100000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] lcg;
      // reset state
      @(negedge clk);
      checks++;
      if (tx_k !== 1'b1 || tx_data !== 8'hBC || rx_rt_valid !== 1'b0 || rx_nrt_valid !== 1'b0 || rx_err !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset actual=k%0b/%02h expected=k1/bc", tx_k, tx_data);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R1: commas while down, even with traffic offered
      repeat (3) drive(0, 0, 8'h00, 0, 0, 2'b00, 0, "R1");
      drive(0, 1, 8'h55, 1, 0, 2'b11, 0, "R1");
      // R3/R4: idle right after link-up uses seeds
      repeat (3) drive(1, 0, 8'h00, 0, 0, 2'b00, 0, "R3");
      // R4/R6: side-channel frame
      drive(1, 0, 8'h00, 1, 1, 2'b00, 0, "R4");
      drive(1, 0, 8'h00, 1, 0, 2'b00, 0, "R6");
      drive(1, 0, 8'h00, 1, 0, 2'b01, 0, "R6");
      drive(1, 0, 8'h00, 1, 0, 2'b10, 0, "R6");
      drive(1, 0, 8'h00, 1, 0, 2'b11, 0, "R4");
      drive(1, 0, 8'h00, 1, 1, 2'b10, 0, "R4");
      // R2/R5: real-time bytes win over offered side-channel symbols
      drive(1, 1, 8'h00, 1, 0, 2'b01, 0, "R2");
      drive(1, 1, 8'hFF, 1, 1, 2'b00, 0, "R5");
      drive(1, 1, 8'hA5, 0, 0, 2'b00, 0, "R2");
      drive(1, 1, 8'hBC, 1, 0, 2'b10, 0, "R2");
      drive(1, 0, 8'h00, 0, 0, 2'b00, 0, "R4");
      // R7: unexpected control character on the receive side
      drive(1, 0, 8'h00, 1, 0, 2'b11, 1, "R7");
      drive(1, 1, 8'h3C, 0, 0, 2'b00, 0, "R7");
      drive(1, 0, 8'h00, 1, 0, 2'b01, 0, "R7");
      // R8: drop link and come back, sync restored by commas
      repeat (2) drive(0, 0, 8'h00, 0, 0, 2'b00, 0, "R8");
      drive(1, 1, 8'h12, 0, 0, 2'b00, 0, "R8");
      drive(1, 0, 8'h00, 1, 0, 2'b10, 0, "R8");
      drive(1, 0, 8'h00, 1, 1, 2'b00, 0, "R8");
      // mixed pattern
      lcg = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         drive(1, lcg[31], lcg[23:16], lcg[30], lcg[29] & lcg[28], lcg[27:26], 0, "R8");
      end
      repeat (4) drive(1, 0, 8'h00, 0, 0, 2'b00, 0, "R3");
      repeat (3) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule